// File: doc/BRIEF.md
# Dual 24-bit Data Pointer Unit

This block holds two 24-bit data pointers, a main one and a shadow one, for an 8-bit core that reaches a large external data space. Each pointer is made of a low, a high and a page byte. A control register picks which pointer is active. It also gives each pointer its own post-access behaviour: hold, step up, step down, or flip the lowest address bit. It can also swap the active pointer after each external data access.

Software writes the pointer bytes and the control register through a small register port. Byte writes always reach the active pointer. The core raises an increment command when it wants the active pointer to count up by one. It pulses an access strobe when it uses the active pointer for an external data transfer. The active pointer appears on the address output. During the strobe cycle the address is the pre-access value, and any post-access change shows from the following cycle. Both pointers and the control register can be read back. Memory is outside the block.

Top module: `dptr_dual`

## Requirements
- R1: A synchronous active-high reset clears both pointers and the control register to zero. Writes, increments and strobes are ignored while reset is high.
- R2: A write with `wr_addr` 0, 1 or 2 loads the low, high or page byte of the active pointer. `wr_addr` 3 loads the control register. `addr_out` always shows the active pointer.
- R3: `inc_req` adds one to the active pointer across all 24 bits, carrying from low to high to page, and FFFFFFh becomes 000000h.
- R4: Control bit 0 selects the active pointer: 0 is main, 1 is shadow. The pointer that is not active never changes.
- R5: On an access strobe the active pointer is modified by its mode code. Code 00 holds it, 01 adds one, 10 subtracts one and 11 inverts address bit 0. `addr_out` in the strobe cycle is the value before the change.
- R6: Post-decrement from 000000h gives FFFFFFh.
- R7: The main pointer's mode sits in control bits 3:2 and the shadow pointer's mode in bits 5:4. An access uses only the mode of the pointer that is active.
- R8: When control bit 6 is set, every access strobe inverts the select bit once the access is done.
- R9: Control bits 7 and 1 always read zero and drop written values. So writing the read value plus one flips only the select bit.
- R10: If a byte write to the active pointer coincides with a strobe or an increment, the written byte lands and the pointer gets no other change. A control write beats the auto-toggle in the same cycle. A strobe together with an increment applies only the strobe's modification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write target: 0 low, 1 high, 2 page, 3 control |
| wr_data | input | 8 | Write data |
| inc_req | input | 1 | Increment the active pointer by one |
| acc_strobe | input | 1 | External data access through the active pointer |
| addr_out | output | 24 | Active pointer value |
| main_ptr | output | 24 | Main pointer readback |
| shad_ptr | output | 24 | Shadow pointer readback |
| ctrl_rd | output | 8 | Control register readback |

## Verification
Several pairs of functions can land in one cycle. A byte write to the active pointer can coincide with an access strobe. A control write can coincide with a strobe while auto-toggle is on. A strobe can also coincide with an increment. The bench raises both inputs in the same clock cycle. It then judges the outcome one cycle later on `addr_out` and `ctrl_rd`. It expects the written byte or control value to stand, the select bit to follow the priority rules, and an increment under a strobe to be dropped. A final readback of both pointers confirms that the side effects fell on the right pointer.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RA_W   = 2;

  typedef enum logic [1:0] {
    PM_PLAIN = 2'b00,
    PM_INC   = 2'b01,
    PM_DEC   = 2'b10,
    PM_FLIP  = 2'b11
  } pmode_e;

  typedef enum logic [RA_W-1:0] {
    RA_LOW  = 2'd0,
    RA_HIGH = 2'd1,
    RA_PAGE = 2'd2,
    RA_CTRL = 2'd3
  } regsel_e;

  // control register field positions (increment-to-toggle relies on bit 1 being empty)
  localparam int unsigned SEL_BIT   = 0;
  localparam int unsigned MMODE_LO  = 2;
  localparam int unsigned SMODE_LO  = 4;
  localparam int unsigned AUTO_BIT  = 6;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h7D;
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
#(
  parameter int unsigned NBYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_hit,
  input  logic [RA_W-1:0]        wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic                   inc_en,
  input  logic                   acc_en,
  input  pmode_e                 mode,
  output logic [NBYTES*BYTE_W-1:0] q
);
  localparam int unsigned AW = NBYTES * BYTE_W;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [NBYTES-1:0] lane_we;
  logic [AW-1:0]     nxt;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_we[g] = wr_hit && (wr_idx == RA_W'(g));
  end

  always_comb begin
    nxt = q;
    if (wr_hit) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (lane_we[b]) nxt[b*BYTE_W +: BYTE_W] = wr_data;
      end
    end else if (acc_en) begin
      unique case (mode)
        PM_PLAIN: nxt = q;
        PM_INC:   nxt = q + ONE;
        PM_DEC:   nxt = q - ONE;
        PM_FLIP:  nxt = {q[AW-1:1], ~q[0]};
        default:  nxt = q;
      endcase
    end else if (inc_en) begin
      nxt = q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R3: a lone increment carries through every byte
  a_r3_inc_carry: assert property (@(posedge clk) disable iff (rst)
    inc_en && !acc_en && !wr_hit |=> q == $past(q) + ONE);

  // R5: plain mode leaves the pointer untouched after an access
  a_r5_plain_hold: assert property (@(posedge clk) disable iff (rst)
    acc_en && !wr_hit && mode == PM_PLAIN |=> $stable(q));

  // R5: bit-flip mode changes only address bit 0
  a_r5_flip_lsb: assert property (@(posedge clk) disable iff (rst)
    acc_en && !wr_hit && mode == PM_FLIP |=>
      (q[AW-1:1] == $past(q[AW-1:1])) && (q[0] != $past(q[0])));

  // R6: post-decrement wraps from zero to all ones
  a_r6_dec_wrap: assert property (@(posedge clk) disable iff (rst)
    acc_en && !wr_hit && mode == PM_DEC && q == '0 |=> &q);

  // R10: a byte write to the low lane wins over any modification
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_hit && wr_idx == RA_W'(0) |=> q[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              acc_strobe,
  output logic              sel,
  output pmode_e            main_mode,
  output pmode_e            shad_mode,
  output logic [BYTE_W-1:0] ctrl_rd
);
  logic auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= 1'b0;
      main_mode <= PM_PLAIN;
      shad_mode <= PM_PLAIN;
      auto_q    <= 1'b0;
    end else if (wr_hit) begin
      sel       <= wr_data[SEL_BIT];
      main_mode <= pmode_e'(wr_data[MMODE_LO +: 2]);
      shad_mode <= pmode_e'(wr_data[SMODE_LO +: 2]);
      auto_q    <= wr_data[AUTO_BIT];
    end else if (acc_strobe && auto_q) begin
      sel <= ~sel;
    end
  end

  assign ctrl_rd = {1'b0, auto_q, shad_mode, main_mode, 1'b0, sel};

  // R8: auto-toggle swaps the active pointer after each access
  a_r8_auto_swap: assert property (@(posedge clk) disable iff (rst)
    acc_strobe && auto_q && !wr_hit |=> sel != $past(sel));

  // R8: without auto-toggle or a write, the select bit holds
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_hit && !(acc_strobe && auto_q) |=> $stable(sel));

  // R9 / R10: a control write lands masked, beating the auto-toggle
  a_r10_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ctrl_rd == ($past(wr_data) & CTRL_MASK));
endmodule

// File: rtl/dptr_dual.sv
module dptr_dual
  import dptr_pkg::*;
#(
  parameter int unsigned NBYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      inc_req,
  input  logic                      acc_strobe,
  output logic [NBYTES*8-1:0]       addr_out,
  output logic [NBYTES*8-1:0]       main_ptr,
  output logic [NBYTES*8-1:0]       shad_ptr,
  output logic [7:0]                ctrl_rd
);
  localparam int unsigned AW   = NBYTES * BYTE_W;
  localparam int unsigned NPTR = 2;

  logic          sel;
  pmode_e        main_mode, shad_mode;
  logic          ctrl_hit, byte_hit;
  logic [AW-1:0] ptr_q [NPTR];

  assign ctrl_hit = wr_en && (wr_addr == RA_CTRL);
  assign byte_hit = wr_en && (wr_addr != RA_CTRL);

  dptr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_hit     (ctrl_hit),
    .wr_data    (wr_data),
    .acc_strobe (acc_strobe),
    .sel        (sel),
    .main_mode  (main_mode),
    .shad_mode  (shad_mode),
    .ctrl_rd    (ctrl_rd)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    logic mine;
    assign mine = (sel == p[0]);
    dptr_reg #(.NBYTES(NBYTES)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (byte_hit && mine),
      .wr_idx  (wr_addr),
      .wr_data (wr_data),
      .inc_en  (inc_req && mine),
      .acc_en  (acc_strobe && mine),
      .mode    ((p == 0) ? main_mode : shad_mode),
      .q       (ptr_q[p])
    );
  end

  assign addr_out = sel ? ptr_q[1] : ptr_q[0];
  assign main_ptr = ptr_q[0];
  assign shad_ptr = ptr_q[1];

  // R4: the idle pointer never moves
  a_r4_shadow_idle: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(ptr_q[1]));
  a_r4_main_idle: assert property (@(posedge clk) disable iff (rst)
    sel |=> $stable(ptr_q[0]));
endmodule

// File: tb/dptr_dual_tb.sv
module dptr_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        inc_req = 1'b0;
  logic        acc_strobe = 1'b0;
  logic [23:0] addr_out, main_ptr, shad_ptr;
  logic [7:0]  ctrl_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dptr_dual dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inc_req(inc_req), .acc_strobe(acc_strobe), .addr_out(addr_out),
    .main_ptr(main_ptr), .shad_ptr(shad_ptr), .ctrl_rd(ctrl_rd)
  );

  // {tag, we, waddr, wdata, inc, acc, expected addr, expected ctrl}
  localparam int NV = 32;
  localparam logic [48:0] VEC [NV] = '{
    {4'd2, 1'b1,2'd0,8'h34,1'b0,1'b0, 24'h000034, 8'h00}, // R2 low byte
    {4'd2, 1'b1,2'd1,8'h12,1'b0,1'b0, 24'h001234, 8'h00}, // R2 high byte
    {4'd2, 1'b1,2'd2,8'hAB,1'b0,1'b0, 24'hAB1234, 8'h00}, // R2 page byte
    {4'd3, 1'b0,2'd0,8'h00,1'b1,1'b0, 24'hAB1235, 8'h00}, // R3 increment
    {4'd5, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1235, 8'h00}, // R5 plain access
    {4'd5, 1'b1,2'd3,8'h04,1'b0,1'b0, 24'hAB1235, 8'h04}, // R5 main post-inc
    {4'd5, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1236, 8'h04}, // R5
    {4'd5, 1'b1,2'd3,8'h08,1'b0,1'b0, 24'hAB1236, 8'h08}, // R5 main post-dec
    {4'd5, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1235, 8'h08}, // R5
    {4'd5, 1'b1,2'd3,8'h0C,1'b0,1'b0, 24'hAB1235, 8'h0C}, // R5 main flip
    {4'd5, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1234, 8'h0C}, // R5
    {4'd5, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1235, 8'h0C}, // R5
    {4'd4, 1'b1,2'd3,8'h0D,1'b0,1'b0, 24'h000000, 8'h0D}, // R4 select shadow
    {4'd7, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'h000000, 8'h0D}, // R7 shadow plain
    {4'd7, 1'b1,2'd3,8'h1D,1'b0,1'b0, 24'h000000, 8'h1D}, // R7
    {4'd7, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'h000001, 8'h1D}, // R7 shadow post-inc
    {4'd6, 1'b1,2'd3,8'h2D,1'b0,1'b0, 24'h000001, 8'h2D}, // R6
    {4'd6, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'h000000, 8'h2D}, // R6
    {4'd6, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hFFFFFF, 8'h2D}, // R6 wrap
    {4'd3, 1'b0,2'd0,8'h00,1'b1,1'b0, 24'h000000, 8'h2D}, // R3 full carry
    {4'd8, 1'b1,2'd3,8'h5C,1'b0,1'b0, 24'hAB1235, 8'h5C}, // R8 auto on
    {4'd8, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'h000000, 8'h5D}, // R8 swap
    {4'd8, 1'b0,2'd0,8'h00,1'b0,1'b1, 24'hAB1234, 8'h5C}, // R8 swap back
    {4'd9, 1'b1,2'd3,8'hFF,1'b0,1'b0, 24'h000001, 8'h7D}, // R9 masked bits
    {4'd9, 1'b1,2'd3,8'h7E,1'b0,1'b0, 24'hAB1234, 8'h7C}, // R9 plus one
    {4'd9, 1'b1,2'd3,8'h7D,1'b0,1'b0, 24'h000001, 8'h7D}, // R9 plus one
    {4'd10,1'b1,2'd0,8'h80,1'b0,1'b1, 24'hAB1234, 8'h7C}, // R10 byte write + access
    {4'd10,1'b1,2'd3,8'h7D,1'b0,1'b1, 24'h000080, 8'h7D}, // R10 ctrl write + access
    {4'd10,1'b0,2'd0,8'h00,1'b1,1'b1, 24'hAB1235, 8'h7C}, // R10 inc + access
    {4'd10,1'b1,2'd3,8'h01,1'b0,1'b0, 24'h000081, 8'h01}, // R10
    {4'd10,1'b0,2'd0,8'h00,1'b1,1'b1, 24'h000081, 8'h01}, // R10 inc dropped
    {4'd3, 1'b0,2'd0,8'h00,1'b1,1'b0, 24'h000082, 8'h01}  // R3
  };

  task automatic check(input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0; inc_req = 1'b0; acc_strobe = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: state during reset
    check(1, "reset addr", {8'd0, addr_out}, 32'd0);
    check(1, "reset ctrl", {24'd0, ctrl_rd}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      wr_en = v[44]; wr_addr = v[43:42]; wr_data = v[41:34];
      inc_req = v[33]; acc_strobe = v[32];
      @(negedge clk);
      idle();
      check(int'(v[48:45]), $sformatf("row %0d addr", i), {8'd0, addr_out}, {8'd0, v[31:8]});
      check(int'(v[48:45]), $sformatf("row %0d ctrl", i), {24'd0, ctrl_rd}, {24'd0, v[7:0]});
    end

    // R4: readback shows the idle pointer kept its value
    check(4, "main readback", {8'd0, main_ptr}, 32'h00AB1235);
    check(4, "shadow readback", {8'd0, shad_ptr}, 32'h00000082);

    // R1: reset mid-run wipes state and ignores a write held during it
    rst = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h7D; acc_strobe = 1'b1;
    @(negedge clk);
    check(1, "reset main", {8'd0, main_ptr}, 32'd0);
    check(1, "reset shadow", {8'd0, shad_ptr}, 32'd0);
    check(1, "reset ctrl held write", {24'd0, ctrl_rd}, 32'd0);
    idle();
    rst = 1'b0;
    @(negedge clk);
    check(1, "after reset addr", {8'd0, addr_out}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule